// File: doc/BRIEF.md
# Burst Packetizer with Send-Time Stamp

This block turns a stream of result samples into bursts of fixed-length packets on a valid/ready stream output that has a last flag at the end of every packet and an end-of-burst flag on the final sample of a burst. A host read begins with a one-cycle start request that carries a packet count. The block then forwards exactly that many packets of `PKT_LEN` samples and stops accepting input until the next request arrives.

When the first sample of a burst is accepted, the block samples a free-running 64-bit time counter, provided its has-time flag is high. It holds that value and presents it as a low word and a high word for the host to read. If no valid time is available at that moment, the block keeps the previously held value and clears its time-valid status.

A single output register sits between input and output. A stalled output therefore holds still, and input acceptance follows the downstream ready signal in the same cycle.

Top module: `burst_packetizer`

## Requirements
- R1: After reset, `m_valid`, `s_ready` and `ts_valid` are 0 and both time-stamp words are 0.
- R2: A sample moves in only when `s_valid` and `s_ready` are both 1, and it moves out only when `m_valid` and `m_ready` are both 1. Output samples appear in input order, each one the cycle after it was accepted.
- R3: While `m_valid` is 1 and `m_ready` is 0, `m_valid`, `m_data`, `m_last` and `m_eob` keep their values into the next cycle.
- R4: `m_last` is 1 on the sample at index `PKT_LEN`-1 of each packet, counting from 0 at the start of the burst, and 0 on every other sample.
- R5: `m_eob` is 1 only on the last sample of packet number `frames_per_read` of the burst, where a value of 0 counts as 1. After that sample has been accepted, `s_ready` stays 0 until the next start request.
- R6: `frames_per_read` is read only in the cycle `start_req` is 1. Changes to it during a burst have no effect.
- R7: When the first sample of a burst is accepted with `ts_has_time` at 1, the stamp takes the `ts_now` value of that cycle and `ts_valid` becomes 1. Changes to `ts_now` at any other time do not alter the stamp.
- R8: When the first sample of a burst is accepted with `ts_has_time` at 0, the stamp keeps its previous value and `ts_valid` becomes 0.
- R9: `ts_lo` carries stamp bits 31:0 and `ts_hi` carries stamp bits 63:32.
- R10: A start request resets the sample and packet counters, even in the middle of a burst. `s_ready` is 0 in the cycle `start_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | One-cycle pulse that begins a host read burst |
| frames_per_read | input | FRM_W | Packets per burst, sampled at start (0 means 1) |
| s_data | input | DATA_W | Input sample |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block accepts an input sample |
| ts_now | input | TS_W | Free-running time counter |
| ts_has_time | input | 1 | The time counter value is valid |
| m_data | output | DATA_W | Output sample |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream accepts the output sample |
| m_last | output | 1 | Last sample of a packet |
| m_eob | output | 1 | Last sample of the burst |
| ts_lo | output | TS_W/2 | Low word of the held stamp |
| ts_hi | output | TS_W/2 | High word of the held stamp |
| ts_valid | output | 1 | Held stamp came from a valid time |

## Verification
The bench builds the block with `PKT_LEN` = 4, `FRM_W` = 3 and 16-bit data. With those values every packet count from 0 through 4 can be swept within a few hundred cycles, under several input-gap and output-stall patterns. Each combination also alternates the has-time flag, so each `m_last`, each `m_eob`, the stop after a burst and the stamp kept across a timeless burst all land within a short run. One burst is abandoned partway through and a new start is issued, which exercises the counter reset.

// File: rtl/bp_pkg.sv
package bp_pkg;
    // per-sample framing marks carried alongside the data
    typedef struct packed {
        logic last;
        logic eob;
    } bp_mark_t;
endpackage

// File: rtl/bp_seq_ctrl.sv
module bp_seq_ctrl
    import bp_pkg::*;
#(
    parameter int PKT_LEN = 256,
    parameter int FRM_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [FRM_W-1:0] frames_per_read,
    input  logic             accept,
    output logic             active,
    output logic             first,
    output bp_mark_t         mark
);
    localparam int SAMP_W = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;
    localparam logic [SAMP_W-1:0] SAMP_END = SAMP_W'(PKT_LEN - 1);

    typedef struct packed {
        logic              active;
        logic              first;
        logic [SAMP_W-1:0] samp;
        logic [FRM_W-1:0]  pkt;
        logic [FRM_W-1:0]  pkt_end;
    } seq_t;

    seq_t seq_d, seq_q;
    logic at_pkt_end;
    logic at_burst_end;

    assign at_pkt_end   = (seq_q.samp == SAMP_END);
    assign at_burst_end = at_pkt_end && (seq_q.pkt == seq_q.pkt_end);

    always_comb begin
        seq_d = seq_q;
        if (start_req) begin
            seq_d.active  = 1'b1;
            seq_d.first   = 1'b1;
            seq_d.samp    = '0;
            seq_d.pkt     = '0;
            seq_d.pkt_end = (frames_per_read == '0) ? '0 : frames_per_read - 1'b1;
        end else if (accept) begin
            seq_d.first = 1'b0;
            if (at_pkt_end) begin
                seq_d.samp = '0;
                if (at_burst_end) begin
                    seq_d.active = 1'b0;
                end else begin
                    seq_d.pkt = seq_q.pkt + 1'b1;
                end
            end else begin
                seq_d.samp = seq_q.samp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign active    = seq_q.active;
    assign first     = seq_q.first;
    assign mark.last = at_pkt_end;
    assign mark.eob  = at_burst_end;
endmodule

// File: rtl/bp_out_stage.sv
module bp_out_stage
    import bp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  bp_mark_t          mark_in,
    input  logic              m_ready,
    output logic              free,
    output logic [DATA_W-1:0] m_data,
    output logic              m_valid,
    output logic              m_last,
    output logic              m_eob
);
    typedef struct packed {
        logic              valid;
        bp_mark_t          mark;
        logic [DATA_W-1:0] data;
    } ostage_t;

    ostage_t os_d, os_q;

    assign free = !os_q.valid || m_ready;

    always_comb begin
        os_d = os_q;
        if (load) begin
            os_d.valid = 1'b1;
            os_d.mark  = mark_in;
            os_d.data  = data_in;
        end else if (m_ready) begin
            os_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            os_q <= '0;
        end else begin
            os_q <= os_d;
        end
    end

    assign m_valid = os_q.valid;
    assign m_data  = os_q.data;
    assign m_last  = os_q.mark.last;
    assign m_eob   = os_q.mark.eob;
endmodule

// File: rtl/bp_ts_latch.sv
module bp_ts_latch #(
    parameter int TS_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [TS_W-1:0]   ts_now,
    input  logic              ts_has_time,
    output logic [TS_W/2-1:0] ts_lo,
    output logic [TS_W/2-1:0] ts_hi,
    output logic              ts_valid
);
    localparam int HALF = TS_W / 2;

    typedef struct packed {
        logic            ok;
        logic [TS_W-1:0] stamp;
    } tsl_t;

    tsl_t tsl_d, tsl_q;

    always_comb begin
        tsl_d = tsl_q;
        if (capture) begin
            tsl_d.ok = ts_has_time;
            if (ts_has_time) begin
                tsl_d.stamp = ts_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tsl_q <= '0;
        end else begin
            tsl_q <= tsl_d;
        end
    end

    assign ts_lo    = tsl_q.stamp[HALF-1:0];
    assign ts_hi    = tsl_q.stamp[TS_W-1:HALF];
    assign ts_valid = tsl_q.ok;
endmodule

// File: rtl/burst_packetizer.sv
module burst_packetizer
    import bp_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int PKT_LEN = 256,
    parameter int FRM_W   = 8,
    parameter int TS_W    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [FRM_W-1:0]  frames_per_read,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [TS_W-1:0]   ts_now,
    input  logic              ts_has_time,
    output logic [DATA_W-1:0] m_data,
    output logic              m_valid,
    input  logic              m_ready,
    output logic              m_last,
    output logic              m_eob,
    output logic [TS_W/2-1:0] ts_lo,
    output logic [TS_W/2-1:0] ts_hi,
    output logic              ts_valid
);
    logic     active;
    logic     first;
    logic     free;
    logic     accept;
    bp_mark_t mark;

    assign s_ready = active && free && !start_req;
    assign accept  = s_valid && s_ready;

    bp_seq_ctrl #(.PKT_LEN(PKT_LEN), .FRM_W(FRM_W)) seq_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_req       (start_req),
        .frames_per_read (frames_per_read),
        .accept          (accept),
        .active          (active),
        .first           (first),
        .mark            (mark)
    );

    bp_out_stage #(.DATA_W(DATA_W)) ostage_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .data_in (s_data),
        .mark_in (mark),
        .m_ready (m_ready),
        .free    (free),
        .m_data  (m_data),
        .m_valid (m_valid),
        .m_last  (m_last),
        .m_eob   (m_eob)
    );

    bp_ts_latch #(.TS_W(TS_W)) tsl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (accept && first),
        .ts_now      (ts_now),
        .ts_has_time (ts_has_time),
        .ts_lo       (ts_lo),
        .ts_hi       (ts_hi),
        .ts_valid    (ts_valid)
    );
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
    parameter int DATA_W  = 32,
    parameter int PKT_LEN = 256,
    parameter int FRM_W   = 8,
    parameter int TS_W    = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_req,
    input logic [FRM_W-1:0]  frames_per_read,
    input logic [DATA_W-1:0] s_data,
    input logic              s_valid,
    input logic              s_ready,
    input logic [TS_W-1:0]   ts_now,
    input logic              ts_has_time,
    input logic [DATA_W-1:0] m_data,
    input logic              m_valid,
    input logic              m_ready,
    input logic              m_last,
    input logic              m_eob,
    input logic [TS_W/2-1:0] ts_lo,
    input logic [TS_W/2-1:0] ts_hi,
    input logic              ts_valid
);
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last) && $stable(m_eob))); // R3

    AST_LOAD_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_valid) |-> $past(s_valid && s_ready)); // R2

    AST_EOB_ENDS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_eob) |-> m_last); // R5

    AST_NO_READY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> !s_ready); // R10

    AST_STAMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_valid && s_ready) |=> ($stable(ts_lo) && $stable(ts_hi) && $stable(ts_valid))); // R7

    AST_TSVALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ts_valid) |-> $past(s_valid && s_ready && !ts_has_time)); // R8
endmodule

bind burst_packetizer bp_checker #(
    .DATA_W  (DATA_W),
    .PKT_LEN (PKT_LEN),
    .FRM_W   (FRM_W),
    .TS_W    (TS_W)
) chk_i (.*);

// File: tb/burst_packetizer_tb_top.sv
module burst_packetizer_tb_top;
    localparam int DW  = 16;
    localparam int P   = 4;
    localparam int FW  = 3;
    localparam int TW  = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_req = 1'b0;
    logic [FW-1:0] frames_per_read = '0;
    logic [DW-1:0] s_data = '0;
    logic          s_valid = 1'b0;
    logic          s_ready;
    logic [TW-1:0] ts_now = '0;
    logic          ts_has_time = 1'b0;
    logic [DW-1:0] m_data;
    logic          m_valid;
    logic          m_ready = 1'b0;
    logic          m_last;
    logic          m_eob;
    logic [31:0]   ts_lo;
    logic [31:0]   ts_hi;
    logic          ts_valid;

    int checks = 0;
    int errors = 0;
    int cyc_g  = 0;
    logic [TW-1:0] exp_ts = '0;
    logic          exp_tsv = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc_g <= cyc_g + 1;

    burst_packetizer #(.DATA_W(DW), .PKT_LEN(P), .FRM_W(FW), .TS_W(TW)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive_ts();
        ts_now = {32'(cyc_g) + 32'h1000_0000, 32'(cyc_g) * 32'd7 + 32'd3};
    endtask

    task automatic run_burst(input int n, input int pat, input bit has);
        int total;
        int sent;
        int ord;
        int cyc;
        bit prev_stall;
        logic [DW-1:0] prev_data;
        logic prev_last;
        logic prev_eob;
        total = ((n == 0) ? 1 : n) * P;
        sent = 0; ord = 0; cyc = 0; prev_stall = 1'b0;
        prev_data = '0; prev_last = 1'b0; prev_eob = 1'b0;
        @(negedge clk);
        start_req = 1'b1; frames_per_read = FW'(n); ts_has_time = has;
        s_valid = 1'b1; m_ready = 1'b1; drive_ts();
        #1;
        chk(s_ready == 1'b0, "R10", "s_ready during start", s_ready, 0);
        @(negedge clk);
        start_req = 1'b0;
        frames_per_read = FW'(7 - n); // R6: must be ignored
        while (ord < total && cyc < 2000) begin
            if (cyc > 0) @(negedge clk);
            drive_ts();
            s_valid = (sent < total) && (pat == 0 || ((cyc + pat) % 3) != 0);
            m_ready = (pat < 2) || ((cyc * pat) % 5) != 1;
            s_data  = DW'(sent);
            #1;
            if (prev_stall) begin
                chk(m_valid && m_data == prev_data && m_last == prev_last && m_eob == prev_eob,
                    "R3", "stalled output held", m_data, prev_data);
            end
            if (s_valid && s_ready) begin
                if (sent == 0) begin
                    exp_tsv = has;
                    if (has) exp_ts = ts_now;
                end
                sent++;
            end
            if (m_valid && m_ready) begin
                chk(m_data == DW'(ord), "R2", "output order", m_data, ord);
                chk(m_last == ((ord % P) == P - 1), "R4", "last flag", m_last, (ord % P) == P - 1);
                chk(m_eob == (ord == total - 1), "R5", "eob flag", m_eob, ord == total - 1);
                ord++;
            end
            prev_stall = m_valid && !m_ready;
            prev_data = m_data; prev_last = m_last; prev_eob = m_eob;
            cyc++;
        end
        chk(ord == total, "R5", "samples delivered", ord, total);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            s_valid = 1'b1; m_ready = 1'b1; drive_ts();
            #1;
            chk(s_ready == 1'b0, "R5", "no intake after burst", s_ready, 0);
        end
        s_valid = 1'b0;
        chk(ts_lo == exp_ts[31:0], "R9", "ts_lo", ts_lo, exp_ts[31:0]);
        chk(ts_hi == exp_ts[63:32], "R9", "ts_hi", ts_hi, exp_ts[63:32]);
        chk(ts_valid == exp_tsv, has ? "R7" : "R8", "ts_valid", ts_valid, exp_tsv);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        chk(m_valid == 0 && s_ready == 0 && ts_valid == 0, "R1", "reset outputs",
            {m_valid, s_ready, ts_valid}, 0);
        chk(ts_lo == 0 && ts_hi == 0, "R1", "reset stamp", {ts_hi, ts_lo}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(s_ready == 1'b0, "R1", "idle no intake", s_ready, 0);

        // R8 before any capture: stamp stays 0
        run_burst(1, 0, 1'b0);
        for (int n = 0; n <= 4; n++) begin
            for (int pat = 0; pat < 4; pat++) begin
                run_burst(n, pat, ((n + pat) % 3) != 0);
            end
        end

        // R10: abandon a burst after two samples and restart
        @(negedge clk);
        start_req = 1'b1; frames_per_read = 3'd3; m_ready = 1'b1; ts_has_time = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        s_valid = 1'b1; s_data = 16'hAAAA;
        @(negedge clk);
        s_data = 16'hBBBB;
        @(negedge clk);
        s_valid = 1'b0;
        @(negedge clk);
        #1;
        chk(m_valid == 1'b0, "R10", "partial burst drained", m_valid, 0);
        run_burst(1, 1, 1'b1);
        run_burst(2, 3, 1'b0);
        finish_run();
    end
endmodule